// File: doc/BRIEF.md
# I2C Master Bit-Level Timing Generator

This block produces the SCL and SDA waveforms of an I2C master, one bus condition at a time. A sequencer above it sends one request at a time: a start, a repeated start, one written bit, one read bit or a stop. The block then works through the edges of that condition. Every edge is spaced by its own programmable count of system clocks. Both lines are open-drain, so the block only ever drives a line low or releases it. It reads the already synchronized line levels back, and uses them to detect a slave that holds SCL low (clock stretching) and to sample SDA.

Each request ends with a single-cycle `done` pulse. The pulse carries the sampled SDA value and a flag that shows whether arbitration was lost during a written bit.

Requests use a valid/ready handshake. The sequencer holds `req_valid`, `req_op` and `req_bit` steady until `req_ready` is seen high at a rising clock edge, and the request is taken at that edge. `req_ready` is high only in two situations: when the bus is idle, and while the block holds SCL low between two requests of one transfer. The result side has no back-pressure. `done` is a one-cycle pulse that the sequencer must capture.

A 3-bit phase code is exported for debug.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, both line drivers are released, `phase` is 0, `done` is 0 and `req_ready` is 1. Whenever `phase` is 0 (idle), both lines are released.
- R2: A start request (`req_op` = 0) taken in idle drives SDA low at the accepting edge. It drives SCL low `cfg_start_hold` cycles later, and `done` pulses in that same cycle.
- R3: For a write bit (`req_op` = 2) or a read bit (`req_op` = 3), SDA keeps its level for `cfg_data_hold` cycles after the request is taken. SDA is then driven low for a written 0, or released for a written 1 or a read. SCL is released `cfg_low_cnt` cycles after that SDA update. SCL stays driven low while `phase` is 3.
- R4: The high-period count starts only in the cycle after SCL is observed high on `scl_in`. SCL is therefore driven low again `cfg_high_cnt` + 1 cycles after the line actually rises. While a slave holds SCL low, the block waits in `phase` 4.
- R5: For every bit, `rx_bit` at the `done` pulse is the `sda_in` level at the rising clock edge that comes `cfg_sample_dly` + 2 cycles after the cycle in which SCL first reads high.
- R6: On a written 1, if SDA is sampled low at the sample point, the block releases both lines and pulses `done` with `arb_lost` = 1. It also returns to `phase` 0.
- R7: A repeated start (`req_op` = 1) releases SDA after `cfg_data_hold` cycles and releases SCL `cfg_low_cnt` cycles later. It drives SDA low `cfg_rstart_setup` + 1 cycles after SCL rises. It then drives SCL low `cfg_start_hold` cycles after that, together with `done`.
- R8: A stop (`req_op` = 4) drives SDA low after `cfg_data_hold` cycles and releases SCL `cfg_low_cnt` cycles later. It releases SDA `cfg_stop_setup` + 1 cycles after SCL rises. It pulses `done` `cfg_stop_hold` cycles after SDA rises, with `phase` back at 0.
- R9: Every taken request produces exactly one `done` pulse, one cycle long. `req_ready` is high only when `phase` is 0 or 3.
- R10: `phase` reports 0 for idle, 1 for start/restart timing, 2 for data hold after an SCL fall, 3 for SCL low, 4 for waiting for SCL to rise, 5 for SCL high and 6 for stop timing. Code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_low_cnt | input | 14 | SCL low time in clocks |
| cfg_high_cnt | input | 14 | SCL high time in clocks, counted once SCL reads high |
| cfg_start_hold | input | 10 | SDA fall to SCL fall for start and restart |
| cfg_rstart_setup | input | 10 | SCL rise to SDA fall for restart (plus one observe cycle) |
| cfg_stop_setup | input | 10 | SCL rise to SDA rise for stop (plus one observe cycle) |
| cfg_stop_hold | input | 14 | SDA rise to end of stop |
| cfg_data_hold | input | 10 | SDA hold after SCL fall before the next bit's level |
| cfg_sample_dly | input | 10 | Sample point within the SCL high time |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | 0 start, 1 restart, 2 write bit, 3 read bit, 4 stop |
| req_bit | input | 1 | Value to write for a write-bit request |
| done | output | 1 | One-cycle end-of-request pulse |
| rx_bit | output | 1 | Sampled SDA of the last bit |
| arb_lost | output | 1 | Arbitration lost, valid with done |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| scl_low_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 drives SDA low, 0 releases it |
| phase | output | 3 | Current phase code (see R10) |

## Verification
The assertions take for granted that every count is at least 1 and that `cfg_sample_dly` is below `cfg_high_cnt`. They also assume that the configuration does not change during a transfer, and that requests come in a legal order: a start only from idle, every other request only after a start. Under these conditions the waits and sample points behave as the requirements state.

The stimulus uses one fixed set of small, distinct counts chosen within these limits. It issues a scripted sequence in which every non-start request follows a start, and it holds each request stable until `req_ready`. A modelled slave pulls SDA or SCL low only at scheduled cycles, to stretch the clock, to move the sampled value across the sample point, and to force an arbitration loss.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_START     = 3'd1,
    PH_LOW_EDGE  = 3'd2,
    PH_LOW       = 3'd3,
    PH_HIGH_EDGE = 3'd4,
    PH_HIGH      = 3'd5,
    PH_STOP      = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRBIT  = 3'd2,
    OP_RDBIT  = 3'd3,
    OP_STOP   = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SHOLD, S_HOLD, S_DHOLD, S_LOW,
    S_HEDGE, S_HIGH, S_RSETUP, S_PSETUP, S_PHOLD
  } step_e;

  function automatic phase_e phase_of(step_e s);
    case (s)
      S_SHOLD, S_RSETUP: return PH_START;
      S_DHOLD:           return PH_LOW_EDGE;
      S_LOW, S_HOLD:     return PH_LOW;
      S_HEDGE:           return PH_HIGH_EDGE;
      S_HIGH:            return PH_HIGH;
      S_PSETUP, S_PHOLD: return PH_STOP;
      default:           return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bt_timer.sv
// Shared interval counter: restarts on every step change, flags the last cycle.
module i2c_bt_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         expired
);
  localparam logic [W:0] ONE = 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign count   = cnt_q;
  // a limit of 0 behaves like 1
  assign expired = ({1'b0, cnt_q} + ONE) >= {1'b0, limit};
endmodule

// File: rtl/i2c_bt_seq.sv
// Step sequencer: walks the edges of one bus condition per request.
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int LW = 14,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_low_cnt,
  input  logic [LW-1:0] cfg_high_cnt,
  input  logic [SW-1:0] cfg_start_hold,
  input  logic [SW-1:0] cfg_rstart_setup,
  input  logic [SW-1:0] cfg_stop_setup,
  input  logic [LW-1:0] cfg_stop_hold,
  input  logic [SW-1:0] cfg_data_hold,
  input  logic [SW-1:0] cfg_sample_dly,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic          req_bit,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [LW-1:0] cnt,
  input  logic          expired,
  output logic          restart,
  output logic [LW-1:0] limit,
  output logic          done,
  output logic          rx_bit,
  output logic          arb_lost,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic [2:0]    phase
);
  step_e st_q, st_d;
  op_e   op_q;
  logic  bit_q;
  logic  scl_lo_q, scl_lo_d, sda_lo_q, sda_lo_d;
  logic  done_q, done_d, rx_q, rx_d, lost_q, lost_d;
  logic  accept, at_sample;

  assign req_ready = (st_q == S_IDLE) || (st_q == S_HOLD);
  assign accept    = req_valid && req_ready;
  assign at_sample = (cnt == LW'(cfg_sample_dly));

  always_comb begin
    case (st_q)
      S_SHOLD:  limit = LW'(cfg_start_hold);
      S_DHOLD:  limit = LW'(cfg_data_hold);
      S_LOW:    limit = cfg_low_cnt;
      S_HIGH:   limit = cfg_high_cnt;
      S_RSETUP: limit = LW'(cfg_rstart_setup);
      S_PSETUP: limit = LW'(cfg_stop_setup);
      S_PHOLD:  limit = cfg_stop_hold;
      default:  limit = '0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    scl_lo_d = scl_lo_q;
    sda_lo_d = sda_lo_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    lost_d   = 1'b0;
    case (st_q)
      S_IDLE:
        if (accept && op_e'(req_op) == OP_START) begin
          st_d     = S_SHOLD;
          sda_lo_d = 1'b1;
        end
      S_SHOLD:
        if (expired) begin
          scl_lo_d = 1'b1;
          done_d   = 1'b1;
          st_d     = S_HOLD;
        end
      S_HOLD:
        if (accept) st_d = S_DHOLD;
      S_DHOLD:
        if (expired) begin
          st_d = S_LOW;
          case (op_q)
            OP_WRBIT: sda_lo_d = !bit_q;
            OP_STOP:  sda_lo_d = 1'b1;
            default:  sda_lo_d = 1'b0;
          endcase
        end
      S_LOW:
        if (expired) begin
          scl_lo_d = 1'b0;
          st_d     = S_HEDGE;
        end
      S_HEDGE:
        if (scl_in) begin
          case (op_q)
            OP_RSTART: st_d = S_RSETUP;
            OP_STOP:   st_d = S_PSETUP;
            default:   st_d = S_HIGH;
          endcase
        end
      S_HIGH: begin
        if (at_sample) rx_d = sda_in;
        if (at_sample && op_q == OP_WRBIT && bit_q && !sda_in) begin
          sda_lo_d = 1'b0;
          scl_lo_d = 1'b0;
          done_d   = 1'b1;
          lost_d   = 1'b1;
          st_d     = S_IDLE;
        end else if (expired) begin
          scl_lo_d = 1'b1;
          done_d   = 1'b1;
          st_d     = S_HOLD;
        end
      end
      S_RSETUP:
        if (expired) begin
          sda_lo_d = 1'b1;
          st_d     = S_SHOLD;
        end
      S_PSETUP:
        if (expired) begin
          sda_lo_d = 1'b0;
          st_d     = S_PHOLD;
        end
      S_PHOLD:
        if (expired) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      default: st_d = S_IDLE;
    endcase
  end

  assign restart = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_START;
      bit_q    <= 1'b1;
      scl_lo_q <= 1'b0;
      sda_lo_q <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= 1'b1;
      lost_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      scl_lo_q <= scl_lo_d;
      sda_lo_q <= sda_lo_d;
      done_q   <= done_d;
      rx_q     <= rx_d;
      lost_q   <= lost_d;
      if (accept) begin
        op_q  <= op_e'(req_op);
        bit_q <= req_bit;
      end
    end
  end

  assign done      = done_q;
  assign rx_bit    = rx_q;
  assign arb_lost  = lost_q;
  assign scl_low_o = scl_lo_q;
  assign sda_low_o = sda_lo_q;
  assign phase     = phase_of(st_q);
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int LW = 14,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_low_cnt,
  input  logic [LW-1:0] cfg_high_cnt,
  input  logic [SW-1:0] cfg_start_hold,
  input  logic [SW-1:0] cfg_rstart_setup,
  input  logic [SW-1:0] cfg_stop_setup,
  input  logic [LW-1:0] cfg_stop_hold,
  input  logic [SW-1:0] cfg_data_hold,
  input  logic [SW-1:0] cfg_sample_dly,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic          req_bit,
  output logic          done,
  output logic          rx_bit,
  output logic          arb_lost,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic [2:0]    phase
);
  logic [LW-1:0] cnt, limit;
  logic          expired, restart;

  i2c_bt_timer #(.W(LW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .limit   (limit),
    .count   (cnt),
    .expired (expired)
  );

  i2c_bt_seq #(.LW(LW), .SW(SW)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_low_cnt      (cfg_low_cnt),
    .cfg_high_cnt     (cfg_high_cnt),
    .cfg_start_hold   (cfg_start_hold),
    .cfg_rstart_setup (cfg_rstart_setup),
    .cfg_stop_setup   (cfg_stop_setup),
    .cfg_stop_hold    (cfg_stop_hold),
    .cfg_data_hold    (cfg_data_hold),
    .cfg_sample_dly   (cfg_sample_dly),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_op           (req_op),
    .req_bit          (req_bit),
    .scl_in           (scl_in),
    .sda_in           (sda_in),
    .cnt              (cnt),
    .expired          (expired),
    .restart          (restart),
    .limit            (limit),
    .done             (done),
    .rx_bit           (rx_bit),
    .arb_lost         (arb_lost),
    .scl_low_o        (scl_low_o),
    .sda_low_o        (sda_low_o),
    .phase            (phase)
  );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       arb_lost,
  input logic       scl_in,
  input logic       scl_low_o,
  input logic       sda_low_o,
  input logic [2:0] phase
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |-> (!scl_low_o && !sda_low_o)); // R1

  AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_low_o) && $past(phase) == 3'd1) |-> (sda_low_o && done)); // R2

  AST_LOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd3 |-> scl_low_o); // R3

  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && !scl_in) |=> phase == 3'd4); // R4

  AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd5 |-> !scl_low_o); // R4

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arb_lost) |-> (!scl_low_o && !sda_low_o && phase == 3'd0)); // R6

  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(phase) == 3'd6) |-> (phase == 3'd0 && !sda_low_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_READY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phase == 3'd0 || phase == 3'd3)); // R9

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd7); // R10
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .arb_lost  (arb_lost),
  .scl_in    (scl_in),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .phase     (phase)
);

// File: tb/i2c_bit_timer_bench.sv
`timescale 1ns/1ps
module i2c_bit_timer_bench;
  localparam int C_LOW = 6, C_HIGH = 5, C_SHOLD = 4, C_RSU = 3;
  localparam int C_PSU = 3, C_PHOLD = 7, C_DHOLD = 2, C_SMP = 2;
  localparam logic [2:0] OPC_START = 3'd0, OPC_RSTART = 3'd1, OPC_WR = 3'd2;
  localparam logic [2:0] OPC_RD = 3'd3, OPC_STOP = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0, req_bit = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_ready, done, rx_bit, arb_lost, scl_low_o, sda_low_o;
  logic [2:0] phase;
  logic       slave_scl_low = 1'b0, slave_sda_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !(scl_low_o || slave_scl_low);
  assign sda_line = !(sda_low_o || slave_sda_low);

  i2c_bit_timer u_i2c_bit_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_low_cnt(14'(C_LOW)), .cfg_high_cnt(14'(C_HIGH)),
    .cfg_start_hold(10'(C_SHOLD)), .cfg_rstart_setup(10'(C_RSU)),
    .cfg_stop_setup(10'(C_PSU)), .cfg_stop_hold(14'(C_PHOLD)),
    .cfg_data_hold(10'(C_DHOLD)), .cfg_sample_dly(10'(C_SMP)),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_bit(req_bit),
    .done(done), .rx_bit(rx_bit), .arb_lost(arb_lost),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .phase(phase)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int   t_scl_rise = 0, t_scl_fall = 0, t_sda_rise = 0, t_sda_fall = 0;
  int   t_acc = 0, t_done = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    if (scl_line && !p_scl) t_scl_rise = cyc;
    if (!scl_line && p_scl) t_scl_fall = cyc;
    if (sda_line && !p_sda) t_sda_rise = cyc;
    if (!sda_line && p_sda) t_sda_fall = cyc;
    p_scl = scl_line;
    p_sda = sda_line;
  end

  int checks = 0, errors = 0, pushed = 0, popped = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    bit    chk_rx;
    bit    rx;
    bit    lost;
  } exp_t;
  exp_t sbq[$];
  exp_t got;

  // monitor: one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual 1 expected 0");
      end else begin
        got = sbq.pop_front();
        popped++;
        check({got.tag, " arb_lost"}, int'(arb_lost), int'(got.lost));
        if (got.chk_rx) check({got.tag, " rx_bit"}, int'(rx_bit), int'(got.rx));
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic b, input string tag,
                       input bit chk_rx, input bit erx, input bit elost);
    exp_t it;
    it.tag = tag; it.chk_rx = chk_rx; it.rx = erx; it.lost = elost;
    sbq.push_back(it);
    pushed++;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b;
    while (!req_ready) @(negedge clk);
    t_acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    t_done = cyc;
    @(negedge clk);
  endtask

  // slave pulls SDA low 'off' cycles after SCL is seen high, lets go after SCL falls
  task automatic slave_pull_at(input int off);
    int r;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    r = cyc;
    while (cyc != r + off) @(negedge clk);
    slave_sda_low = 1'b1;
    while (scl_line) @(negedge clk);
    @(negedge clk);
    slave_sda_low = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl released", int'(scl_low_o), 0);
    check("R1 sda released", int'(sda_low_o), 0);
    check("R1 phase idle", int'(phase), 0);
    check("R1 ready", int'(req_ready), 1);
    check("R1 done low", int'(done), 0);

    issue(OPC_START, 1'b0, "R2 start", 0, 0, 0);
    check("R2 sda fall to scl fall", t_scl_fall - t_sda_fall, C_SHOLD);
    check("R2 done with scl fall", t_done - t_scl_fall, 0);
    check("R10 phase low after start", int'(phase), 3);
    check("R9 ready between requests", int'(req_ready), 1);

    issue(OPC_WR, 1'b1, "R5 write one", 1, 1, 0);
    check("R3 hold before sda rise", t_sda_rise - t_acc, C_DHOLD);
    check("R3 sda to scl rise", t_scl_rise - t_sda_rise, C_LOW);

    issue(OPC_WR, 1'b0, "R5 write zero", 1, 0, 0);
    check("R3 hold before sda fall", t_sda_fall - t_acc, C_DHOLD);
    check("R3 low time", t_scl_rise - t_sda_fall, C_LOW);
    check("R4 high time", t_scl_fall - t_scl_rise, C_HIGH + 1);

    fork
      issue(OPC_RD, 1'b0, "R5 read at sample point", 1, 0, 0);
      slave_pull_at(C_SMP + 1);
    join
    check("R3 read releases sda", t_sda_rise - t_acc, C_DHOLD);

    fork
      issue(OPC_RD, 1'b0, "R5 read after sample point", 1, 1, 0);
      slave_pull_at(C_SMP + 2);
    join

    slave_scl_low = 1'b1;
    fork
      issue(OPC_WR, 1'b1, "R4 stretched bit", 1, 1, 0);
      begin
        @(negedge clk);
        while (scl_low_o) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R4 phase while stretched", int'(phase), 4);
        check("R9 ready while busy", int'(req_ready), 0);
        slave_scl_low = 1'b0;
      end
    join
    check("R4 high time after stretch", t_scl_fall - t_scl_rise, C_HIGH + 1);

    issue(OPC_RSTART, 1'b0, "R7 restart", 0, 0, 0);
    check("R7 scl rise to sda fall", t_sda_fall - t_scl_rise, C_RSU + 1);
    check("R7 sda fall to scl fall", t_scl_fall - t_sda_fall, C_SHOLD);

    slave_sda_low = 1'b1;
    issue(OPC_WR, 1'b1, "R6 arbitration", 0, 0, 1);
    check("R6 scl released", int'(scl_low_o), 0);
    check("R6 sda released", int'(sda_low_o), 0);
    check("R6 phase idle", int'(phase), 0);
    slave_sda_low = 1'b0;
    repeat (2) @(negedge clk);

    issue(OPC_START, 1'b0, "R2 start again", 0, 0, 0);
    issue(OPC_WR, 1'b0, "R5 write zero again", 1, 0, 0);
    issue(OPC_STOP, 1'b0, "R8 stop", 0, 0, 0);
    check("R8 scl rise to sda rise", t_sda_rise - t_scl_rise, C_PSU + 1);
    check("R8 sda rise to done", t_done - t_sda_rise, C_PHOLD);
    check("R8 phase idle", int'(phase), 0);
    check("R8 lines released", int'(scl_low_o || sda_low_o), 0);

    repeat (3) @(negedge clk);
    check("R9 one done per request", popped, pushed);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule